// File: doc/BRIEF.md
# Deflection-Routed Torus Node Switch

This block is the router for a single node of a two-dimensional torus in which each dimension carries traffic in one direction only. Each cycle it can take one flit from the node to its west and one from the node to its south. It can send one flit to the node to its east and one to the node to its north. Those links wrap around at the grid edges, and the wiring between nodes is done outside this block. A local processing element injects flits through a valid/ready channel. It receives the flits addressed to this node through an ejection channel that has no backpressure, so the element must take whatever is presented in the same cycle.

The switch has no buffers. Every flit that arrives is forwarded one clock later. A flit that cannot get the output it wants is sent out on the other output. The router first moves a flit along x until its x coordinate matches the node, then along y. The west input has fixed priority over the south input, and both in-network inputs have priority over local injection. The node's own coordinates, the coordinate widths and the payload width are parameters. The coordinate widths must be at least the base-2 logarithm of the grid dimensions.

Top module: `torusDeflectSwitch`

## Requirements
- R1: While rstN is low at a rising edge, eastValid, northValid and ejValid are low after that edge, and injReady is low for as long as rstN is low.
- R2: A flit is X_W+Y_W+DATA_W bits wide. Bits [X_W-1:0] hold the destination x, bits [X_W+Y_W-1:X_W] hold the destination y, and the bits above hold the payload. The switch forwards all of these bits unchanged.
- R3: Every flit the switch accepts (a valid west or south flit, or an injected flit with injValid and injReady both high) appears on exactly one output one cycle later. No other output flit appears.
- R4: A flit whose x and y both equal the node's coordinates is presented on ejData with ejValid one cycle later, unless the other in-network input is ejecting. When both west and south flits are addressed here, the west flit is ejected.
- R5: At most one flit is ejected per cycle. A node-addressed flit that is not ejected leaves on east, or on north if east is taken.
- R6: A flit whose x differs from the node's prefers east. A flit whose x matches but whose y differs prefers north.
- R7: The west flit always gets its preferred output. A south flit whose preferred output is already taken leaves on the other output.
- R8: injReady is low exactly when west and south are both valid and neither is ejected, or when rstN is low. Otherwise it is high.
- R9: An injected flit takes its preferred output if that output is free, and the other output if not. A self-addressed injected flit prefers east and is never ejected directly. When injReady is low, injValid has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| westValid | input | 1 | Flit present from west neighbour |
| westData | input | FLIT_W | Flit from west neighbour |
| southValid | input | 1 | Flit present from south neighbour |
| southData | input | FLIT_W | Flit from south neighbour |
| injValid | input | 1 | Local element offers a flit |
| injData | input | FLIT_W | Flit offered by local element |
| injReady | output | 1 | Switch accepts the offered flit this cycle |
| eastValid | output | 1 | Flit present toward east neighbour |
| eastData | output | FLIT_W | Flit toward east neighbour |
| northValid | output | 1 | Flit present toward north neighbour |
| northData | output | FLIT_W | Flit toward north neighbour |
| ejValid | output | 1 | Flit delivered to local element |
| ejData | output | FLIT_W | Flit delivered to local element |

## Verification
The properties assume the neighbours obey the same one-flit-per-link-per-cycle rule as this switch: a west or south flit is present whenever its valid is high and is never withheld. They also assume the local element samples the ejection port every cycle. The stimulus keeps to this by driving all inputs once per cycle on the falling edge and treating injValid as a plain offer that the switch may decline. Random destinations are drawn from inside the grid. This mixes self-addressed, x-bound and y-bound flits, and directed cycles force double ejection, both outputs busy, and injection that is refused.

// File: rtl/torusSwitchPkg.sv
package torusSwitchPkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_WEST  = 2'd1,
    SRC_SOUTH = 2'd2,
    SRC_INJ   = 2'd3
  } srcSel_e;

  // Routing wishes of one incoming flit, relative to this node
  typedef struct packed {
    logic atHome;   // destination is this node
    logic wantEast; // preferred output is east (else north)
  } routeReq_t;

  // Strobes from control to datapath
  typedef struct packed {
    srcSel_e eastSel;
    srcSel_e northSel;
    srcSel_e ejectSel;
  } xbarCtl_t;

endpackage

// File: rtl/torusRouteCompute.sv
module torusRouteCompute
  import torusSwitchPkg::*;
#(
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic [X_W+Y_W-1:0] hdr,
  output routeReq_t          req
);
  localparam logic [X_W-1:0] HOME_X = X_W'(MY_X);
  localparam logic [Y_W-1:0] HOME_Y = Y_W'(MY_Y);

  logic xMatch, yMatch;

  always_comb begin
    xMatch       = (hdr[X_W-1:0] == HOME_X);
    yMatch       = (hdr[X_W+Y_W-1:X_W] == HOME_Y);
    req.atHome   = xMatch && yMatch;
    // x-first: travel east until x matches; home flits also lean east
    req.wantEast = !xMatch || yMatch;
  end
endmodule

// File: rtl/torusSwitchCtrl.sv
module torusSwitchCtrl
  import torusSwitchPkg::*;
(
  input  logic      rstN,
  input  logic      westValid,
  input  logic      southValid,
  input  logic      injValid,
  input  routeReq_t westReq,
  input  routeReq_t southReq,
  input  routeReq_t injReq,
  output xbarCtl_t  ctl,
  output logic      injReady
);
  logic westLeft, southLeft, eastFree, northFree;

  always_comb begin
    ctl.eastSel  = SRC_NONE;
    ctl.northSel = SRC_NONE;
    ctl.ejectSel = SRC_NONE;
    westLeft     = westValid;
    southLeft    = southValid;

    // single ejection slot, west first
    if (westValid && westReq.atHome) begin
      ctl.ejectSel = SRC_WEST;
      westLeft     = 1'b0;
    end else if (southValid && southReq.atHome) begin
      ctl.ejectSel = SRC_SOUTH;
      southLeft    = 1'b0;
    end

    // west always wins its preferred link
    if (westLeft) begin
      if (westReq.wantEast) ctl.eastSel  = SRC_WEST;
      else                  ctl.northSel = SRC_WEST;
    end

    // south takes preferred link or is deflected
    if (southLeft) begin
      if (southReq.wantEast && ctl.eastSel == SRC_NONE)        ctl.eastSel  = SRC_SOUTH;
      else if (!southReq.wantEast && ctl.northSel == SRC_NONE) ctl.northSel = SRC_SOUTH;
      else if (ctl.eastSel == SRC_NONE)                        ctl.eastSel  = SRC_SOUTH;
      else                                                     ctl.northSel = SRC_SOUTH;
    end

    eastFree  = (ctl.eastSel == SRC_NONE);
    northFree = (ctl.northSel == SRC_NONE);
    injReady  = rstN && (eastFree || northFree);

    // injection fills a leftover link
    if (injValid && injReady) begin
      if (injReq.wantEast && eastFree)        ctl.eastSel  = SRC_INJ;
      else if (!injReq.wantEast && northFree) ctl.northSel = SRC_INJ;
      else if (eastFree)                      ctl.eastSel  = SRC_INJ;
      else                                    ctl.northSel = SRC_INJ;
    end
  end
endmodule

// File: rtl/torusSwitchDatapath.sv
module torusSwitchDatapath
  import torusSwitchPkg::*;
#(
  parameter int FLIT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  xbarCtl_t          ctl,
  input  logic [FLIT_W-1:0] westData,
  input  logic [FLIT_W-1:0] southData,
  input  logic [FLIT_W-1:0] injData,
  output logic              eastValid,
  output logic [FLIT_W-1:0] eastData,
  output logic              northValid,
  output logic [FLIT_W-1:0] northData,
  output logic              ejValid,
  output logic [FLIT_W-1:0] ejData
);
  localparam int N_OUT = 3;

  srcSel_e           sel   [N_OUT];
  logic [FLIT_W-1:0] muxed [N_OUT];
  logic              vReg  [N_OUT];
  logic [FLIT_W-1:0] dReg  [N_OUT];

  always_comb begin
    sel[0] = ctl.eastSel;
    sel[1] = ctl.northSel;
    sel[2] = ctl.ejectSel;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : gOut
    always_comb begin
      unique case (sel[g])
        SRC_WEST:  muxed[g] = westData;
        SRC_SOUTH: muxed[g] = southData;
        SRC_INJ:   muxed[g] = injData;
        default:   muxed[g] = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vReg[g] <= 1'b0;
        dReg[g] <= '0;
      end else begin
        vReg[g] <= (sel[g] != SRC_NONE);
        dReg[g] <= muxed[g];
      end
    end
  end

  assign eastValid  = vReg[0];
  assign eastData   = dReg[0];
  assign northValid = vReg[1];
  assign northData  = dReg[1];
  assign ejValid    = vReg[2];
  assign ejData     = dReg[2];
endmodule

// File: rtl/torusDeflectSwitch.sv
module torusDeflectSwitch
  import torusSwitchPkg::*;
#(
  parameter int X_DIM  = 4,
  parameter int Y_DIM  = 4,
  parameter int X_W    = (X_DIM > 1) ? $clog2(X_DIM) : 1,
  parameter int Y_W    = (Y_DIM > 1) ? $clog2(Y_DIM) : 1,
  parameter int DATA_W = 8,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0,
  localparam int HDR_W  = X_W + Y_W,
  localparam int FLIT_W = HDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              westValid,
  input  logic [FLIT_W-1:0] westData,
  input  logic              southValid,
  input  logic [FLIT_W-1:0] southData,
  input  logic              injValid,
  input  logic [FLIT_W-1:0] injData,
  output logic              injReady,
  output logic              eastValid,
  output logic [FLIT_W-1:0] eastData,
  output logic              northValid,
  output logic [FLIT_W-1:0] northData,
  output logic              ejValid,
  output logic [FLIT_W-1:0] ejData
);
  localparam int N_IN = 3;

  logic [HDR_W-1:0] hdr [N_IN];
  routeReq_t        req [N_IN];
  xbarCtl_t         ctl;

  always_comb begin
    hdr[0] = westData[HDR_W-1:0];
    hdr[1] = southData[HDR_W-1:0];
    hdr[2] = injData[HDR_W-1:0];
  end

  for (genvar g = 0; g < N_IN; g++) begin : gRoute
    torusRouteCompute #(
      .X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)
    ) i_route (
      .hdr(hdr[g]),
      .req(req[g])
    );
  end

  torusSwitchCtrl i_ctrl (
    .rstN      (rstN),
    .westValid (westValid),
    .southValid(southValid),
    .injValid  (injValid),
    .westReq   (req[0]),
    .southReq  (req[1]),
    .injReq    (req[2]),
    .ctl       (ctl),
    .injReady  (injReady)
  );

  torusSwitchDatapath #(.FLIT_W(FLIT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .westData  (westData),
    .southData (southData),
    .injData   (injData),
    .eastValid (eastValid),
    .eastData  (eastData),
    .northValid(northValid),
    .northData (northData),
    .ejValid   (ejValid),
    .ejData    (ejData)
  );
endmodule

// File: rtl/torusSwitchChecker.sv
module torusSwitchChecker #(
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int DATA_W = 8,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0,
  localparam int FLIT_W = X_W + Y_W + DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              westValid,
  input logic [FLIT_W-1:0] westData,
  input logic              southValid,
  input logic [FLIT_W-1:0] southData,
  input logic              injValid,
  input logic              injReady,
  input logic              eastValid,
  input logic              northValid,
  input logic              ejValid,
  input logic [FLIT_W-1:0] ejData
);
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  logic westHome, southHome, ejHome;
  always_comb begin
    westHome  = westData[X_W-1:0] == HX && westData[X_W+Y_W-1:X_W] == HY;
    southHome = southData[X_W-1:0] == HX && southData[X_W+Y_W-1:X_W] == HY;
    ejHome    = ejData[X_W-1:0] == HX && ejData[X_W+Y_W-1:X_W] == HY;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> !eastValid && !northValid && !ejValid);

  assert_flit_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $countones({eastValid, northValid, ejValid}) ==
      $past($countones({westValid, southValid, injValid && injReady})));

  assert_eject_home_R4: assert property (@(posedge clk) disable iff (!rstN)
    ejValid |-> ejHome);

  assert_west_eject_R4: assert property (@(posedge clk) disable iff (!rstN)
    westValid && westHome |=> ejValid && ejData == $past(westData));

  assert_ready_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    westValid && southValid && !westHome && !southHome |-> !injReady);

  assert_ready_open_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(westValid && southValid && !westHome && !southHome) |-> injReady);
endmodule

bind torusDeflectSwitch torusSwitchChecker #(
  .X_W(X_W), .Y_W(Y_W), .DATA_W(DATA_W), .MY_X(MY_X), .MY_Y(MY_Y)
) i_chk (
  .clk(clk), .rstN(rstN),
  .westValid(westValid), .westData(westData),
  .southValid(southValid), .southData(southData),
  .injValid(injValid), .injReady(injReady),
  .eastValid(eastValid), .northValid(northValid),
  .ejValid(ejValid), .ejData(ejData)
);

// File: tb/test_torusDeflectSwitch.sv
`timescale 1ns/1ps
module test_torusDeflectSwitch;
  localparam int XD = 4, YD = 4, XW = 2, YW = 2, DW = 8;
  localparam int MX = 1, MY = 2;
  localparam int FW = XW + YW + DW;

  typedef struct packed {
    logic eV; logic [FW-1:0] eD;
    logic nV; logic [FW-1:0] nD;
    logic jV; logic [FW-1:0] jD;
    logic rdy;
  } expect_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic westValid = 0, southValid = 0, injValid = 0;
  logic [FW-1:0] westData = '0, southData = '0, injData = '0;
  logic injReady, eastValid, northValid, ejValid;
  logic [FW-1:0] eastData, northData, ejData;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  torusDeflectSwitch #(.X_DIM(XD), .Y_DIM(YD), .X_W(XW), .Y_W(YW),
    .DATA_W(DW), .MY_X(MX), .MY_Y(MY)) i_torusDeflectSwitch (
    .clk(clk), .rstN(rstN),
    .westValid(westValid), .westData(westData),
    .southValid(southValid), .southData(southData),
    .injValid(injValid), .injData(injData), .injReady(injReady),
    .eastValid(eastValid), .eastData(eastData),
    .northValid(northValid), .northData(northData),
    .ejValid(ejValid), .ejData(ejData));

  function automatic logic [FW-1:0] mk(int x, int y, int p);
    return {DW'(p), YW'(y), XW'(x)};   // R2 layout
  endfunction
  function automatic logic home(logic [FW-1:0] f);
    return f[XW-1:0] == XW'(MX) && f[XW+YW-1:XW] == YW'(MY);
  endfunction
  function automatic logic prefE(logic [FW-1:0] f);
    return f[XW-1:0] != XW'(MX) || home(f);
  endfunction

  function automatic expect_t model(logic wv, logic [FW-1:0] wd,
      logic sv, logic [FW-1:0] sd, logic iv, logic [FW-1:0] id);
    expect_t r;
    logic wl, sl;
    r = '0; wl = wv; sl = sv;
    if (wv && home(wd)) begin r.jV = 1; r.jD = wd; wl = 0; end
    else if (sv && home(sd)) begin r.jV = 1; r.jD = sd; sl = 0; end
    if (wl) begin
      if (prefE(wd)) begin r.eV = 1; r.eD = wd; end
      else begin r.nV = 1; r.nD = wd; end
    end
    if (sl) begin
      if ((prefE(sd) && !r.eV) || (r.nV && !r.eV)) begin r.eV = 1; r.eD = sd; end
      else begin r.nV = 1; r.nD = sd; end
    end
    r.rdy = !(r.eV && r.nV);
    if (iv && r.rdy) begin
      if ((prefE(id) && !r.eV) || (r.nV && !r.eV)) begin r.eV = 1; r.eD = id; end
      else begin r.nV = 1; r.nD = id; end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [FW:0] act, logic [FW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic wv, logic [FW-1:0] wd,
      logic sv, logic [FW-1:0] sd, logic iv, logic [FW-1:0] id);
    expect_t e;
    @(negedge clk);
    westValid = wv; westData = wd; southValid = sv; southData = sd;
    injValid = iv; injData = id;
    e = model(wv, wd, sv, sd, iv, id);
    #1 chk({tag, " R8 ready"}, {{FW{1'b0}}, injReady}, {{FW{1'b0}}, e.rdy});
    @(posedge clk); #1;
    chk({tag, " R3 east"},  {eastValid, eastValid ? eastData : '0},   {e.eV, e.eV ? e.eD : '0});
    chk({tag, " R3 north"}, {northValid, northValid ? northData : '0}, {e.nV, e.nV ? e.nD : '0});
    chk({tag, " R4 eject"}, {ejValid, ejValid ? ejData : '0},         {e.jV, e.jV ? e.jD : '0});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outs", {{FW-2{1'b0}}, eastValid, northValid, ejValid}, '0);
    chk("R1 reset ready", {{FW{1'b0}}, injReady}, '0);
    @(negedge clk); rstN = 1'b1;

    // R4/R5: both home, west ejected, south deflected east
    step("R5 dual home", 1, mk(MX, MY, 8'hA1), 1, mk(MX, MY, 8'hB2), 1, mk(0, 0, 8'h11));
    // R6/R7: both want east, south deflected north; inject refused (R9)
    step("R7 east clash", 1, mk(3, 0, 8'h21), 1, mk(0, 3, 8'h22), 1, mk(2, 2, 8'h33));
    // R6: both want north, south goes east
    step("R6 north clash", 1, mk(MX, 0, 8'h41), 1, mk(MX, 3, 8'h42), 0, '0);
    // R9: injection, x match goes north
    step("R9 inj north", 0, '0, 0, '0, 1, mk(MX, 0, 8'h55));
    // R9: self-addressed injection leaves east
    step("R9 inj self", 0, '0, 0, '0, 1, mk(MX, MY, 8'h66));
    // R9: injection deflected when preferred link taken
    step("R9 inj deflect", 1, mk(0, 1, 8'h71), 0, '0, 1, mk(3, 3, 8'h77));
    // R4: south ejected, west passes north, inject takes east
    step("R4 south eject", 1, mk(MX, 0, 8'h81), 1, mk(MX, MY, 8'h82), 1, mk(0, 0, 8'h88));
    // R2: payload extremes
    step("R2 payload", 1, mk(0, 0, 8'hFF), 1, mk(MX, MY, 8'h00), 0, '0);

    for (int i = 0; i < 400; i++) begin
      step("R3 random",
        1'($urandom), mk($urandom % XD, $urandom % YD, $urandom),
        1'($urandom), mk($urandom % YD == 0 ? MX : $urandom % XD,
                         $urandom % YD == 0 ? MY : $urandom % YD, $urandom),
        1'($urandom), mk($urandom % XD, $urandom % YD, $urandom));
    end

    // R1 mid-run reset with traffic present
    @(negedge clk);
    rstN = 0; westValid = 1; westData = mk(MX, MY, 1); southValid = 1;
    southData = mk(0, 0, 2); injValid = 1;
    #1 chk("R1 ready low", {{FW{1'b0}}, injReady}, '0);
    @(posedge clk); #1;
    chk("R1 mid reset", {{FW-2{1'b0}}, eastValid, northValid, ejValid}, '0);
    @(negedge clk); rstN = 1; westValid = 0; southValid = 0; injValid = 0;
    step("R1 after", 0, '0, 0, '0, 0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule